// File: doc/BRIEF.md
# Sync-Character Hunt Receiver

This block is the serial receive front end for a character-oriented synchronous link. It takes a recovered serial bit stream together with a one-cycle bit enable that marks each valid bit. The block starts in hunt mode after reset, and a hunt command puts it back into hunt mode at any time. In hunt mode it compares every new 8-bit window of the stream with a programmable sync character. The first match moves it to the synchronized state. From then on it packs the following bits into bytes and gives each completed byte to a downstream FIFO write port, together with a one-cycle valid strobe.

A separate detector watches for a constant high level on the line, which marks an inactive line. It counts consecutive ones and reports the line as inactive once the run is longer than seven bits. Both detectors advance only on bit-enable cycles, so when no receive clock is present the reported status stays as it is.

Top module: `sync_hunt_rx`

## Requirements
- R1: After reset, `synced`, `line_idle`, `rx_valid` and `sync_irq` are all 0, and the receiver is already hunting.
- R2: While hunting, bits are shifted in LSB first: the first bit of a character ends up in bit 0. `synced` becomes 1 on the clock edge that samples the last bit of a window equal to `sync_char`, with no further confirmation.
- R3: A `hunt_cmd` pulse clears `synced` on the next edge, also when the block is already synchronized. It then restarts the search, and a match must use at least 8 bits received after the command.
- R4: When `irq_en` is 1, `sync_irq` pulses for exactly one cycle on the edge where `synced` rises.
- R5: When `irq_en` is 0, `sync_irq` stays 0 even when sync is found.
- R6: Once synchronized, the bits that follow the sync character are packed LSB first into bytes. After every 8th bit, `rx_byte` is updated and `rx_valid` is 1 for one cycle.
- R7: `rx_valid` is never asserted unless the block was synchronized.
- R8: `line_idle` becomes 1 on the edge that samples the 8th consecutive one, that is, more than 7 ones in a row. Seven ones leave it at 0.
- R9: Any received zero clears `line_idle` and restarts the count of ones.
- R10: In cycles with `bit_en` low, `line_idle` and the match and packing state do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Marks the cycle that carries a received bit |
| bit_in | input | 1 | Received serial bit |
| hunt_cmd | input | 1 | One-cycle command to clear sync and search again |
| sync_char | input | 8 | Sync character to search for |
| irq_en | input | 1 | Enables the sync-found interrupt pulse |
| synced | output | 1 | Receiver is in the synchronized state |
| line_idle | output | 1 | Constant high level detected on the line |
| sync_irq | output | 1 | One-cycle pulse when sync is found |
| rx_byte | output | 8 | Assembled data byte |
| rx_valid | output | 1 | One-cycle write strobe for `rx_byte` |

## Verification
A wrong hunt or match state shows up at the ports within one bit time. `synced` rises one bit too early or too late, or it rises after fewer than eight bits have been received since a hunt command. A packing counter that is out of phase with the sync character shifts every forwarded byte, so the scoreboard sees a wrong byte value at the first strobe. A miscounted run of ones moves the edge of `line_idle` by one bit around the seventh and eighth ones.

// File: rtl/sync_hunt_pkg.sv
// Package: shared types for the sync-character hunt receiver.
// Assumes: nothing beyond standard SystemVerilog.
package sync_hunt_pkg;

    // Receiver framing state
    typedef enum logic {
        ST_HUNT = 1'b0,
        ST_SYNC = 1'b1
    } rx_state_e;

endpackage

// File: rtl/sync_match.sv
// Module: sync_match
// Shifts received bits LSB first into a window and reports a match with the
// sync pattern once at least WIDTH bits have arrived since the last restart.
// Assumes: bit_en marks valid bits; restart is a single-cycle command.
module sync_match #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_en,
    input  logic             bit_in,
    input  logic             restart,
    input  logic [WIDTH-1:0] pattern,
    output logic             match
);
    localparam int FILL_W = $clog2(WIDTH + 1);

    logic [WIDTH-1:0]  win_q;
    logic [WIDTH-1:0]  win_next;
    logic [FILL_W-1:0] fill_q;
    logic              full;

    // Next window: new bit enters at the top, oldest falls out of bit 0
    always_comb begin
        win_next = {bit_in, win_q[WIDTH-1:1]};
    end

    // Enough fresh bits for a full window including the current one
    always_comb begin
        full  = !restart && (fill_q >= FILL_W'(WIDTH - 1));
        match = bit_en && full && (win_next == pattern);
    end

    // Window register advances only on bit cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= '0;
        end else if (bit_en) begin
            win_q <= win_next;
        end
    end

    // Count fresh bits since restart, saturating at WIDTH
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= '0;
        end else if (restart) begin
            fill_q <= bit_en ? FILL_W'(1) : '0;
        end else if (bit_en && (fill_q != FILL_W'(WIDTH))) begin
            fill_q <= fill_q + FILL_W'(1);
        end
    end

endmodule

// File: rtl/byte_packer.sv
// Module: byte_packer
// Packs received bits LSB first into WIDTH-bit words and strobes each
// completed word for one cycle.
// Assumes: clear is held while the receiver is not synchronized, so the
// first bit after clear drops is bit 0 of a word.
module byte_packer #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             bit_en,
    input  logic             bit_in,
    output logic [WIDTH-1:0] word,
    output logic             word_valid
);
    localparam int CNT_W = $clog2(WIDTH);

    logic [WIDTH-1:0] acc_q;
    logic [WIDTH-1:0] acc_next;
    logic [CNT_W-1:0] cnt_q;
    logic             last_bit;

    // Shift the new bit in from the top
    always_comb begin
        acc_next = {bit_in, acc_q[WIDTH-1:1]};
        last_bit = (cnt_q == CNT_W'(WIDTH - 1));
    end

    // Accumulate, count bits and emit a word after every WIDTH bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q      <= '0;
            cnt_q      <= '0;
            word       <= '0;
            word_valid <= 1'b0;
        end else if (clear) begin
            cnt_q      <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= 1'b0;
            if (bit_en) begin
                acc_q <= acc_next;
                if (last_bit) begin
                    cnt_q      <= '0;
                    word       <= acc_next;
                    word_valid <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + CNT_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/idle_detect.sv
// Module: idle_detect
// Reports an inactive line once more than RUN_LIMIT consecutive ones have
// been received; any zero clears the run and the status.
// Assumes: bit_en marks valid bits; with no bit_en nothing changes.
module idle_detect #(
    parameter int RUN_LIMIT = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic bit_in,
    output logic idle
);
    localparam int RUN_W = $clog2(RUN_LIMIT + 2);

    logic [RUN_W-1:0] run_q;

    // Count ones and raise idle when the run passes the limit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
            idle  <= 1'b0;
        end else if (bit_en) begin
            if (!bit_in) begin
                run_q <= '0;
                idle  <= 1'b0;
            end else if (run_q == RUN_W'(RUN_LIMIT)) begin
                idle  <= 1'b1;
            end else begin
                run_q <= run_q + RUN_W'(1);
            end
        end
    end

endmodule

// File: rtl/sync_hunt_rx.sv
// Module: sync_hunt_rx
// Top of the sync-character hunt receiver. Hunts for the sync character,
// holds the synchronized state, raises an optional sync interrupt and
// forwards packed bytes; reports a constant-high line separately.
// Assumes: bit_in is already recovered and qualified by bit_en.
module sync_hunt_rx #(
    parameter int CHAR_W    = 8,
    parameter int RUN_LIMIT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic              bit_in,
    input  logic              hunt_cmd,
    input  logic [CHAR_W-1:0] sync_char,
    input  logic              irq_en,
    output logic              synced,
    output logic              line_idle,
    output logic              sync_irq,
    output logic [CHAR_W-1:0] rx_byte,
    output logic              rx_valid
);
    import sync_hunt_pkg::*;

    rx_state_e state_q;
    logic      found;
    logic      pack_clear;

    sync_match #(.WIDTH(CHAR_W)) i_match (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_en  (bit_en),
        .bit_in  (bit_in),
        .restart (hunt_cmd),
        .pattern (sync_char),
        .match   (found)
    );

    // Packing runs only in sync and stops at once on a hunt command
    always_comb begin
        pack_clear = (state_q != ST_SYNC) || hunt_cmd;
    end

    byte_packer #(.WIDTH(CHAR_W)) i_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (pack_clear),
        .bit_en     (bit_en),
        .bit_in     (bit_in),
        .word       (rx_byte),
        .word_valid (rx_valid)
    );

    idle_detect #(.RUN_LIMIT(RUN_LIMIT)) i_idle (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_en (bit_en),
        .bit_in (bit_in),
        .idle   (line_idle)
    );

    // Hunt/sync state and the sync-found interrupt pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_HUNT;
            sync_irq <= 1'b0;
        end else begin
            sync_irq <= 1'b0;
            if (hunt_cmd) begin
                state_q <= ST_HUNT;
            end else if ((state_q == ST_HUNT) && found) begin
                state_q  <= ST_SYNC;
                sync_irq <= irq_en;
            end
        end
    end

    // Status output
    always_comb begin
        synced = (state_q == ST_SYNC);
    end

endmodule

// File: rtl/sync_hunt_rx_checker.sv
// Module: sync_hunt_rx_checker
// Port-level temporal checks for sync_hunt_rx, attached with bind.
// Assumes: synchronous active-low reset.
module sync_hunt_rx_checker (
    input logic clk,
    input logic rst_n,
    input logic bit_en,
    input logic bit_in,
    input logic hunt_cmd,
    input logic irq_en,
    input logic synced,
    input logic line_idle,
    input logic sync_irq,
    input logic rx_valid
);
    AST_HUNT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        hunt_cmd |=> !synced); // R3
    AST_IRQ_ON_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        sync_irq |-> (synced && !$past(synced))); // R4
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        sync_irq |-> $past(irq_en)); // R5
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R6
    AST_NO_DATA_UNSYNCED: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(synced)); // R7
    AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !bit_in) |=> !line_idle); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(line_idle)); // R10
endmodule

bind sync_hunt_rx sync_hunt_rx_checker i_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .bit_in    (bit_in),
    .hunt_cmd  (hunt_cmd),
    .irq_en    (irq_en),
    .synced    (synced),
    .line_idle (line_idle),
    .sync_irq  (sync_irq),
    .rx_valid  (rx_valid)
);

// File: tb/test_sync_hunt_rx.sv
// Bench: scoreboard for sync_hunt_rx. The driver queues expected bytes,
// and the monitor compares each strobed byte against the queue.
module test_sync_hunt_rx;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] SYN = 8'h16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       bit_in = 1'b0;
    logic       hunt_cmd = 1'b0;
    logic [7:0] sync_char = SYN;
    logic       irq_en = 1'b0;
    logic       synced, line_idle, sync_irq, rx_valid;
    logic [7:0] rx_byte;

    int checks = 0;
    int errors = 0;
    int irq_seen = 0;
    logic [7:0] expq[$];

    sync_hunt_rx i_sync_hunt_rx (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .bit_in(bit_in),
        .hunt_cmd(hunt_cmd), .sync_char(sync_char), .irq_en(irq_en),
        .synced(synced), .line_idle(line_idle), .sync_irq(sync_irq),
        .rx_byte(rx_byte), .rx_valid(rx_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: pop and compare each strobed byte; count interrupt pulses
    always @(negedge clk) begin
        if (rst_n && sync_irq) irq_seen++;
        if (rst_n && rx_valid) begin
            if (expq.size() == 0) begin
                check("R7 unexpected byte", rx_byte, 8'hxx);
            end else begin
                check("R6 byte value", rx_byte, expq.pop_front());
            end
        end
    end

    // Send one bit; outputs are settled at the return
    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_in = b;
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] v, input bit expect_out);
        if (expect_out) expq.push_back(v);
        for (int i = 0; i < 8; i++) send_bit(v[i]);
    endtask

    task automatic hunt();
        @(negedge clk);
        hunt_cmd = 1'b1;
        @(negedge clk);
        hunt_cmd = 1'b0;
    endtask

    initial begin
        repeat (CLK_PERIOD * 20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 synced", {7'b0, synced}, 8'h0);
        check("R1 line_idle", {7'b0, line_idle}, 8'h0);
        check("R1 rx_valid", {7'b0, rx_valid}, 8'h0);
        check("R1 sync_irq", {7'b0, sync_irq}, 8'h0);

        // R2/R4: noise then sync character, interrupt enabled
        irq_en = 1'b1;
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        for (int i = 0; i < 7; i++) send_bit(SYN[i]);
        check("R2 no early sync", {7'b0, synced}, 8'h0);
        send_bit(SYN[7]);
        check("R2 synced on last bit", {7'b0, synced}, 8'h1);
        check("R4 one irq pulse", 8'(irq_seen), 8'd1);

        // R6: bytes forwarded from the bit after sync
        send_byte(8'hA5, 1'b1);
        send_byte(8'h3C, 1'b1);
        check("R6 queue drained", 8'(expq.size()), 8'd0);

        // R3: hunt while synced clears sync; R7: no bytes while hunting
        hunt();
        check("R3 hunt clears sync", {7'b0, synced}, 8'h0);
        send_byte(8'h5A, 1'b0);
        check("R3 still hunting", {7'b0, synced}, 8'h0);

        // R5: resync with interrupt disabled
        irq_en = 1'b0;
        send_byte(SYN, 1'b0);
        check("R5 resynced", {7'b0, synced}, 8'h1);
        check("R5 no irq", 8'(irq_seen), 8'd1);
        send_byte(8'h81, 1'b1);
        check("R6 queue drained", 8'(expq.size()), 8'd0);

        // R3: fresh bits needed after hunt (window already holds SYN? no: send 7 bits)
        hunt();
        for (int i = 1; i < 8; i++) send_bit(SYN[i]);
        check("R3 seven bits no sync", {7'b0, synced}, 8'h0);

        // R8/R9/R10: line idle detection
        send_bit(1'b0);
        for (int i = 0; i < 7; i++) send_bit(1'b1);
        check("R8 seven ones not idle", {7'b0, line_idle}, 8'h0);
        send_bit(1'b1);
        check("R8 eighth one idle", {7'b0, line_idle}, 8'h1);
        bit_in = 1'b0;
        repeat (6) @(negedge clk);
        check("R10 idle held without bit_en", {7'b0, line_idle}, 8'h1);
        send_bit(1'b0);
        check("R9 zero clears idle", {7'b0, line_idle}, 8'h0);
        for (int i = 0; i < 7; i++) send_bit(1'b1);
        check("R9 count restarted", {7'b0, line_idle}, 8'h0);
        check("R7 no stray bytes", 8'(expq.size()), 8'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule